// File: doc/BRIEF.md
# Display shutdown sequencer

This block controls the orderly switch-off of a raster display. While the set is running it produces the horizontal drive as a line-rate pulse train of nominal width. When a standby command arrives it takes a snapshot of three configuration bits. It then waits for the vertical scan in progress to finish, and after that for the following vertical flyback. At that point it starts a slow stop: the horizontal pulse width falls step by step to nothing.

When the flyback ends, two optional actions start together with the slow stop. The first is a beam-discharge request of selectable length. The second is a request to park the vertical deflection in overscan, so the screen stays dark while the tube discharges. All durations are counted on an internal clock-enable tick, and every count is a parameter.

A done flag rises once the drive has reached zero and any discharge window has closed. The block then holds its final state until reset or a power-up request.

Top module: `disp_shutdown_seq`

## Requirements
- R1: After reset, beam_req_o, vhold_o and done_o are low. While idle, hdrv_o carries pulses of exactly NOM_ON clocks, one per line.
- R2: A standby request accepted while idle makes the block wait first for a scan-end strobe and then for a flyback-end strobe. A flyback-end strobe seen before the scan-end strobe is ignored. No output changes until the flyback strobe has been taken.
- R3: The clock edge that samples the accepted flyback-end strobe starts the slow stop. From then on, the on-time drops by one every STEP_TICKS ticks, and one tick lasts TICK_DIV clocks. It reaches zero NOM_ON*STEP_TICKS*TICK_DIV clocks after that edge. Pulse widths never grow during the slow stop, and the last nonzero pulse is one clock wide.
- R4: hdrv_o has a period of LINE_CYC clocks. Each period starts with a high pulse whose width is the on-time latched at the start of that period, so a pulse is never cut short.
- R5: The discharge window applies when the snapshot bit beam_en_i is 1. beam_req_o then rises in the first cycle after the flyback edge and stays high for BEAM_SHORT ticks if the snapshot bit long_sel_i is 0, or BEAM_LONG ticks if it is 1.
- R6: When the snapshot bit beam_en_i is 0, beam_req_o stays low for the whole sequence.
- R7: When the snapshot bit hold_en_i is 1, vhold_o rises in the same cycle the slow stop starts and stays high through the done state. When it is 0, vhold_o stays low.
- R8: done_o rises one clock after the later of two events: the on-time reaching zero and the discharge window closing. It then holds, with hdrv_o low and beam_req_o low.
- R9: The configuration inputs are sampled only when standby is accepted, and later changes to them have no effect. A standby request that arrives during a running or finished sequence is ignored.
- R10: A power-up request in the done state returns the block to idle on the next edge. This clears done_o and vhold_o and restores nominal pulses. A power-up request in any other state is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| stby_req_i | input | 1 | Standby command |
| pwr_up_req_i | input | 1 | Power-up request, leaves the done state |
| vscan_end_i | input | 1 | Strobe: vertical scan finished |
| vfly_end_i | input | 1 | Strobe: vertical flyback finished |
| beam_en_i | input | 1 | Enable fixed beam-current discharge |
| hold_en_i | input | 1 | Enable vertical overscan hold |
| long_sel_i | input | 1 | Discharge window length: 0 short, 1 long |
| hdrv_o | output | 1 | Horizontal drive pulse train |
| beam_req_o | output | 1 | Fixed beam-current request |
| vhold_o | output | 1 | Hold vertical deflection in overscan |
| done_o | output | 1 | Shutdown complete |

## Verification
A wrong sequencer state shows up as one of two failures. The outputs may start moving before the second strobe. Or a flipped configuration input may change which outputs move. In both cases the symptom appears in the cycle right after the offending strobe. A miscounted tick or step shows up at two points: the close of the discharge window and the rise of the done flag, each off by whole ticks. An error in the latched width shows up within one line as a pulse that is wider than the one before, or that is not a clean run.

// File: rtl/dss_pkg.sv
package dss_pkg;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_WAIT_SCAN = 3'd1,
    ST_WAIT_FLY  = 3'd2,
    ST_RAMP      = 3'd3,
    ST_DONE      = 3'd4
  } dss_state_e;

  typedef struct packed {
    logic beam_en;
    logic hold_en;
    logic long_sel;
  } dss_cfg_t;

endpackage

// File: rtl/dss_rst_sync.sv
module dss_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_no = sync_q[1];

endmodule

// File: rtl/dss_tick_gen.sv
// Clock-enable tick: high for one clock every TICK_DIV clocks while run_i
// is high. The count phase restarts whenever run_i is low. TICK_DIV >= 2.
module dss_tick_gen #(
  parameter int unsigned TICK_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);

  localparam int unsigned CW = $clog2(TICK_DIV);
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i) begin
      cnt_d = '0;
    end else if (cnt_q == LAST) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign tick_o = run_i && (cnt_q == LAST);

endmodule

// File: rtl/dss_ramp.sv
// On-time register: nominal at rest, one step down every STEP_TICKS ticks.
module dss_ramp #(
  parameter int unsigned NOM_ON     = 8,
  parameter int unsigned STEP_TICKS = 4,
  parameter int unsigned OW         = $clog2(NOM_ON + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          restore_i,
  input  logic          tick_i,
  output logic [OW-1:0] on_time_o,
  output logic          zero_o
);

  localparam logic [OW-1:0] NOM = OW'(NOM_ON);

  logic [OW-1:0] on_time_q, on_time_d;
  logic          step_en;

  generate
    if (STEP_TICKS <= 1) begin : g_every_tick
      assign step_en = tick_i;
    end else begin : g_step_count
      localparam int unsigned SW = $clog2(STEP_TICKS);
      localparam logic [SW-1:0] SLAST = SW'(STEP_TICKS - 1);
      logic [SW-1:0] sc_q, sc_d;

      always_comb begin
        sc_d = sc_q;
        if (start_i || restore_i) begin
          sc_d = '0;
        end else if (tick_i && (on_time_q != '0)) begin
          sc_d = (sc_q == SLAST) ? '0 : sc_q + 1'b1;
        end
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          sc_q <= '0;
        end else begin
          sc_q <= sc_d;
        end
      end

      assign step_en = tick_i && (sc_q == SLAST);
    end
  endgenerate

  always_comb begin
    on_time_d = on_time_q;
    if (start_i || restore_i) begin
      on_time_d = NOM;
    end else if (step_en && (on_time_q != '0)) begin
      on_time_d = on_time_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      on_time_q <= NOM;
    end else begin
      on_time_q <= on_time_d;
    end
  end

  assign on_time_o = on_time_q;
  assign zero_o    = (on_time_q == '0);

  AST_ONTIME_NONINC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !restore_i) |=> (on_time_q <= $past(on_time_q)))
    else $error("on-time grew without a reload"); // R3

endmodule

// File: rtl/dss_beam_win.sv
// Discharge window: armed at ramp start, closes after a tick count chosen
// by the latched length select.
module dss_beam_win #(
  parameter int unsigned BEAM_SHORT = 12,
  parameter int unsigned BEAM_LONG  = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic en_i,
  input  logic long_i,
  input  logic tick_i,
  output logic busy_o
);

  localparam int unsigned BW = $clog2(BEAM_LONG + 1);
  localparam logic [BW-1:0] N_SHORT = BW'(BEAM_SHORT);
  localparam logic [BW-1:0] N_LONG  = BW'(BEAM_LONG);
  localparam logic [BW-1:0] N_ONE   = BW'(1);

  logic          busy_q, busy_d;
  logic [BW-1:0] cnt_q, cnt_d;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (start_i) begin
      busy_d = en_i;
      cnt_d  = long_i ? N_LONG : N_SHORT;
    end else if (busy_q && tick_i) begin
      if (cnt_q == N_ONE) begin
        busy_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy_o = busy_q;

  AST_BEAM_RISE_ON_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(start_i))
    else $error("discharge window opened without a ramp start"); // R5

endmodule

// File: rtl/dss_line_pwm.sv
// Line-rate pulse generator; the width is captured at each period start.
module dss_line_pwm #(
  parameter int unsigned LINE_CYC = 16,
  parameter int unsigned OW       = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [OW-1:0] on_time_i,
  output logic          hdrv_o
);

  localparam int unsigned PW = $clog2(LINE_CYC);
  localparam logic [PW-1:0] PLAST = PW'(LINE_CYC - 1);

  logic [PW-1:0] pc_q, pc_d;
  logic [OW-1:0] lat_q, lat_d;
  logic          wrap;

  assign wrap = (pc_q == PLAST);

  always_comb begin
    pc_d  = wrap ? '0 : pc_q + 1'b1;
    lat_d = wrap ? on_time_i : lat_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= PLAST;
      lat_q <= '0;
    end else begin
      pc_q  <= pc_d;
      lat_q <= lat_d;
    end
  end

  assign hdrv_o = (32'(pc_q) < 32'(lat_q));

  AST_WIDTH_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_q != '0) |-> $stable(lat_q))
    else $error("pulse width changed inside a line"); // R4

endmodule

// File: rtl/dss_ctrl.sv
// Sequence control: idle, wait for scan end, wait for flyback end, slow
// stop, done.
module dss_ctrl
  import dss_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       stby_req_i,
  input  logic       pwr_up_req_i,
  input  logic       vscan_end_i,
  input  logic       vfly_end_i,
  input  dss_cfg_t   cfg_i,
  input  logic       ramp_zero_i,
  input  logic       beam_busy_i,
  output dss_state_e state_o,
  output dss_cfg_t   cfg_o,
  output logic       start_o,
  output logic       restore_o,
  output logic       vhold_o,
  output logic       done_o
);

  dss_state_e state_q, state_d;
  dss_cfg_t   cfg_q, cfg_d;

  always_comb begin
    state_d = state_q;
    cfg_d   = cfg_q;
    unique case (state_q)
      ST_IDLE: begin
        if (stby_req_i) begin
          state_d = ST_WAIT_SCAN;
          cfg_d   = cfg_i;
        end
      end
      ST_WAIT_SCAN: if (vscan_end_i) state_d = ST_WAIT_FLY;
      ST_WAIT_FLY:  if (vfly_end_i)  state_d = ST_RAMP;
      ST_RAMP:      if (ramp_zero_i && !beam_busy_i) state_d = ST_DONE;
      ST_DONE:      if (pwr_up_req_i) state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cfg_q   <= '0;
    end else begin
      state_q <= state_d;
      cfg_q   <= cfg_d;
    end
  end

  assign state_o   = state_q;
  assign cfg_o     = cfg_q;
  assign start_o   = (state_q == ST_WAIT_FLY) && vfly_end_i;
  assign restore_o = (state_q == ST_DONE) && pwr_up_req_i;
  assign vhold_o   = ((state_q == ST_RAMP) || (state_q == ST_DONE)) && cfg_q.hold_en;
  assign done_o    = (state_q == ST_DONE);

  AST_CFG_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |=> $stable(cfg_q))
    else $error("configuration snapshot moved mid-sequence"); // R9

  AST_DONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (ramp_zero_i && !beam_busy_i))
    else $error("done while drive or discharge still active"); // R8

  AST_DONE_FROM_RAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_DONE) && ($past(state_q) != ST_DONE)) |-> ($past(state_q) == ST_RAMP))
    else $error("done entered without a slow stop"); // R2

endmodule

// File: rtl/disp_shutdown_seq.sv
module disp_shutdown_seq
  import dss_pkg::*;
#(
  parameter int unsigned LINE_CYC   = 16,
  parameter int unsigned NOM_ON     = 8,
  parameter int unsigned TICK_DIV   = 4,
  parameter int unsigned STEP_TICKS = 4,
  parameter int unsigned BEAM_SHORT = 12,
  parameter int unsigned BEAM_LONG  = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stby_req_i,
  input  logic pwr_up_req_i,
  input  logic vscan_end_i,
  input  logic vfly_end_i,
  input  logic beam_en_i,
  input  logic hold_en_i,
  input  logic long_sel_i,
  output logic hdrv_o,
  output logic beam_req_o,
  output logic vhold_o,
  output logic done_o
);

  localparam int unsigned OW = $clog2(NOM_ON + 1);

  logic          rst_n_s;
  dss_state_e    state;
  dss_cfg_t      cfg_in, cfg_lat;
  logic          start, restore, tick, ramp_zero, beam_busy;
  logic [OW-1:0] on_time;

  assign cfg_in = '{beam_en: beam_en_i, hold_en: hold_en_i, long_sel: long_sel_i};

  dss_rst_sync i_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_s)
  );

  dss_ctrl i_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_n_s),
    .stby_req_i   (stby_req_i),
    .pwr_up_req_i (pwr_up_req_i),
    .vscan_end_i  (vscan_end_i),
    .vfly_end_i   (vfly_end_i),
    .cfg_i        (cfg_in),
    .ramp_zero_i  (ramp_zero),
    .beam_busy_i  (beam_busy),
    .state_o      (state),
    .cfg_o        (cfg_lat),
    .start_o      (start),
    .restore_o    (restore),
    .vhold_o      (vhold_o),
    .done_o       (done_o)
  );

  dss_tick_gen #(.TICK_DIV(TICK_DIV)) i_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_n_s),
    .run_i  (state == ST_RAMP),
    .tick_o (tick)
  );

  dss_ramp #(.NOM_ON(NOM_ON), .STEP_TICKS(STEP_TICKS), .OW(OW)) i_ramp (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_s),
    .start_i   (start),
    .restore_i (restore),
    .tick_i    (tick),
    .on_time_o (on_time),
    .zero_o    (ramp_zero)
  );

  dss_beam_win #(.BEAM_SHORT(BEAM_SHORT), .BEAM_LONG(BEAM_LONG)) i_beam (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_s),
    .start_i (start),
    .en_i    (cfg_lat.beam_en),
    .long_i  (cfg_lat.long_sel),
    .tick_i  (tick),
    .busy_o  (beam_busy)
  );

  dss_line_pwm #(.LINE_CYC(LINE_CYC), .OW(OW)) i_pwm (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_s),
    .on_time_i (on_time),
    .hdrv_o    (hdrv_o)
  );

  assign beam_req_o = beam_busy;

endmodule

// File: tb/test_disp_shutdown_seq.sv
module test_disp_shutdown_seq;

  localparam int LINE_CYC   = 16;
  localparam int NOM_ON     = 8;
  localparam int TICK_DIV   = 4;
  localparam int STEP_TICKS = 4;
  localparam int BEAM_SHORT = 12;
  localparam int BEAM_LONG  = 16;
  localparam int RAMP_CLK   = NOM_ON * STEP_TICKS * TICK_DIV;

  localparam int EV_VH_RISE   = 1;
  localparam int EV_BM_RISE   = 2;
  localparam int EV_BM_FALL   = 3;
  localparam int EV_DN_RISE   = 4;
  localparam int EV_VH_FALL   = 5;
  localparam int EV_DN_FALL   = 6;

  logic clk = 1'b0;
  logic rst_n;
  logic stby, pwr_up, vscan_end, vfly_end, beam_en, hold_en, long_sel;
  logic hdrv, beam_req, vhold, done;

  always #10 clk = ~clk;

  disp_shutdown_seq #(
    .LINE_CYC(LINE_CYC), .NOM_ON(NOM_ON), .TICK_DIV(TICK_DIV),
    .STEP_TICKS(STEP_TICKS), .BEAM_SHORT(BEAM_SHORT), .BEAM_LONG(BEAM_LONG)
  ) i_disp_shutdown_seq (
    .clk_i(clk), .rst_ni(rst_n), .stby_req_i(stby), .pwr_up_req_i(pwr_up),
    .vscan_end_i(vscan_end), .vfly_end_i(vfly_end), .beam_en_i(beam_en),
    .hold_en_i(hold_en), .long_sel_i(long_sel), .hdrv_o(hdrv),
    .beam_req_o(beam_req), .vhold_o(vhold), .done_o(done)
  );

  int     n_checks = 0;
  int     n_err    = 0;
  longint cyc      = 0;
  bit     finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int     kind;
    longint at;
    string  req;
  } exp_t;

  exp_t sb_q[$];

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push(int kind, longint at, string req);
    exp_t e;
    e.kind = kind;
    e.at   = at;
    e.req  = req;
    sb_q.push_back(e);
  endtask

  task automatic observe(int kind);
    exp_t e;
    if (sb_q.size() == 0) begin
      check(1'b0, "R9", "unexpected output event", kind, 0);
    end else begin
      e = sb_q.pop_front();
      check(e.kind == kind, e.req, "event kind", kind, e.kind);
      check(e.at == cyc, e.req, "event cycle", cyc, e.at);
    end
  endtask

  // Monitor state
  bit mon_en    = 1'b0;
  logic vh_p, bm_p, dn_p, hd_p;
  bit rise_seen = 1'b0;
  int run_len   = 0;
  int pwm_mode  = 0;   // 0 idle widths, 1 slow stop, 2 must be quiet
  int last_w    = NOM_ON;
  int min_w     = NOM_ON;
  int idle_pulses = 0;
  int quiet_hi  = 0;
  int beam_hi   = 0;

  always @(negedge clk) begin
    if (mon_en) begin
      if (vhold && !vh_p)    observe(EV_VH_RISE);
      if (beam_req && !bm_p) observe(EV_BM_RISE);
      if (!beam_req && bm_p) observe(EV_BM_FALL);
      if (done && !dn_p)     observe(EV_DN_RISE);
      if (!vhold && vh_p)    observe(EV_VH_FALL);
      if (!done && dn_p)     observe(EV_DN_FALL);

      if (hdrv && !hd_p) begin
        rise_seen = 1'b1;
        run_len   = 0;
      end
      if (hdrv) run_len++;
      if (!hdrv && hd_p && rise_seen) begin
        if (pwm_mode == 0) begin
          check(run_len == NOM_ON, "R4", "idle pulse width", run_len, NOM_ON);
          idle_pulses++;
        end else if (pwm_mode == 1) begin
          check(run_len <= last_w, "R3", "slow-stop width not growing", run_len, last_w);
          last_w = run_len;
          if (run_len < min_w) min_w = run_len;
        end
      end
      if (pwm_mode == 2 && hdrv) quiet_hi++;
      if (beam_req) beam_hi++;

      vh_p = vhold;
      bm_p = beam_req;
      dn_p = done;
      hd_p = hdrv;
    end
  end

  // Watchdog
  always @(posedge clk) begin
    if (cyc > 20000 && !finished) begin
      finished = 1'b1;
      n_checks++;
      n_err++;
      $display("FAIL R2 watchdog: actual=%0d expected=%0d", cyc, 20000);
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

  task automatic run_seq(bit be, bit he, bit ls);
    longint c0, c1, t_done, beam_len, span;
    beam_len = (ls ? BEAM_LONG : BEAM_SHORT) * TICK_DIV;

    // Accept standby with one configuration, then flip the inputs (R9)
    @(negedge clk);
    beam_en = be; hold_en = he; long_sel = ls; stby = 1'b1;
    @(negedge clk);
    stby = 1'b0; beam_en = ~be; hold_en = ~he; long_sel = ~ls;
    repeat (3) @(negedge clk);
    vfly_end = 1'b1;                 // R2: early flyback strobe must be ignored
    @(negedge clk);
    vfly_end = 1'b0; stby = 1'b1;    // R9: repeated standby ignored
    @(negedge clk);
    stby = 1'b0;
    repeat (5) @(negedge clk);
    check(!beam_req && !vhold && !done, "R2", "outputs before scan end",
          {beam_req, vhold, done}, 0);
    vscan_end = 1'b1;
    @(negedge clk);
    vscan_end = 1'b0;
    repeat (4) @(negedge clk);
    check(!beam_req && !vhold && !done, "R2", "outputs before flyback end",
          {beam_req, vhold, done}, 0);

    // Flyback end: slow stop starts on the next edge
    beam_hi  = 0;
    vfly_end = 1'b1;
    c0       = cyc + 1;
    pwm_mode = 1; last_w = NOM_ON; min_w = NOM_ON;
    if (he) push(EV_VH_RISE, c0, "R7");
    if (be) begin
      push(EV_BM_RISE, c0, "R5");
      push(EV_BM_FALL, c0 + beam_len, "R5");
    end
    span   = (be && beam_len > RAMP_CLK) ? beam_len : RAMP_CLK;
    t_done = c0 + span + 1;
    push(EV_DN_RISE, t_done, "R8");
    @(negedge clk);
    vfly_end = 1'b0;

    // Stray requests during the slow stop (R9, R10)
    repeat (10) @(negedge clk);
    stby = 1'b1; pwr_up = 1'b1;
    @(negedge clk);
    stby = 1'b0; pwr_up = 1'b0;

    while (cyc < t_done + LINE_CYC) @(negedge clk);
    check(min_w == 1, "R3", "last nonzero slow-stop width", min_w, 1);
    if (be) check(beam_hi == beam_len, "R5", "discharge window cycles", beam_hi, beam_len);
    else    check(beam_hi == 0, "R6", "discharge window cycles", beam_hi, 0);

    pwm_mode = 2; quiet_hi = 0;
    stby = 1'b1;                     // R9: standby in done ignored
    @(negedge clk);
    stby = 1'b0;
    repeat (3 * LINE_CYC) @(negedge clk);
    check(quiet_hi == 0, "R8", "drive cycles after done", quiet_hi, 0);
    check(done == 1'b1, "R8", "done held", done, 1);
    check(beam_req == 1'b0, "R8", "beam request in done", beam_req, 0);
    check(vhold == he, "R7", "overscan hold level in done", vhold, he);

    // Power-up returns to idle
    pwr_up = 1'b1;
    c1 = cyc + 1;
    if (he) push(EV_VH_FALL, c1, "R10");
    push(EV_DN_FALL, c1, "R10");
    pwm_mode = 0; idle_pulses = 0;
    @(negedge clk);
    pwr_up = 1'b0;
    repeat (3 * LINE_CYC) @(negedge clk);
    check(idle_pulses >= 2, "R10", "nominal pulses after power-up", idle_pulses, 2);
    check(sb_q.size() == 0, "R10", "pending expected events", sb_q.size(), 0);
  endtask

  initial begin
    rst_n = 1'b0;
    stby = 1'b0; pwr_up = 1'b0; vscan_end = 1'b0; vfly_end = 1'b0;
    beam_en = 1'b0; hold_en = 1'b0; long_sel = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(beam_req == 1'b0, "R1", "beam request after reset", beam_req, 0);
    check(vhold == 1'b0, "R1", "overscan hold after reset", vhold, 0);
    check(done == 1'b0, "R1", "done after reset", done, 0);
    vh_p = vhold; bm_p = beam_req; dn_p = done; hd_p = hdrv;
    pwm_mode = 0; idle_pulses = 0;
    mon_en = 1'b1;
    pwr_up = 1'b1;                   // R10: power-up while idle is ignored
    @(negedge clk);
    pwr_up = 1'b0;
    repeat (3 * LINE_CYC) @(negedge clk);
    check(idle_pulses >= 2, "R1", "idle pulses seen", idle_pulses, 2);

    run_seq(1'b1, 1'b1, 1'b0);
    run_seq(1'b1, 1'b0, 1'b1);
    run_seq(1'b0, 1'b1, 1'b1);

    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

endmodule